// File: doc/BRIEF.md
# AAL5 Transmit Trailer Generator

This block sits in the transmit path of a cell segmenter. Each packet arrives as a stream of bytes that is already cut into 48-byte cell payloads. The block keeps a 32-bit CRC running over every payload byte of the packet and carries the partial value from one cell to the next. When the segmenter marks a cell as the last one of its packet, the block overwrites the final eight bytes of that cell with the trailer. The trailer holds the control field, the length field and the finished CRC.

The control and length values come from the packet descriptor. They are latched only on the byte that starts the packet and are used for nothing except filling the trailer. Cell boundaries come from a byte position counter that restarts on every packet-start marker. A fresh start marker therefore recovers cleanly from a packet that was cut short. Every byte leaves the block one clock after it enters, with its markers and a cell-end flag beside it.

Top module: `aal5_tail_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released with no input, `outValid` is 0.
- R2: Each accepted byte appears on the outputs exactly one clock later, with `outSop` and `outLast` equal to the input markers. Bytes of cells not marked last pass through unchanged.
- R3: The CRC uses the polynomial 0x04C11DB7 and is shifted in most significant bit first. It is preset to all ones on the packet-start byte and accumulates across all cells of the packet. In the last cell it covers bytes 0 to 43, which include the substituted control and length bytes. A CRC over the whole emitted packet, trailer included, therefore yields the residue 0xC704DD7B.
- R4: In a cell marked last, bytes 40–41 carry the control field and bytes 42–43 carry the length field, each most significant byte first. Together they form one 32-bit word with control in bits 31–16 and length in bits 15–0.
- R5: In a cell marked last, bytes 44–47 carry the ones' complement of the accumulated CRC, most significant byte first.
- R6: The descriptor inputs are sampled only on a packet-start byte. Changes at any other time do not alter the trailer.
- R7: A packet-start byte resets the byte position to 0 and reloads the CRC preset, even in the middle of a cell or a trailer.
- R8: `outCellEnd` marks every 48th byte counted from the packet start. The length field never affects this.
- R9: A clock with `inValid` low produces `outValid` low on the next clock and leaves the position, the CRC and the latched fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Payload byte |
| inSop | input | 1 | Byte is the first of a packet |
| inLast | input | 1 | Byte belongs to the last cell of its packet |
| descCtrl | input | 16 | Descriptor control field, sampled with inSop |
| descLen | input | 16 | Descriptor length field, sampled with inSop |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Payload byte with the trailer filled in |
| outSop | output | 1 | Delayed packet-start marker |
| outLast | output | 1 | Delayed last-cell marker |
| outCellEnd | output | 1 | Byte is byte 47 of its cell |

## Verification
A packet-start byte reloads the CRC preset and latches the descriptor fields in the same cycle that its own byte is folded into the CRC. That byte must therefore be accumulated from the preset and not from the stale value. The bench provokes this with packets sent back to back and with restarts in the middle of a cell and in the middle of a trailer. In each case the start byte arrives directly after bytes of an unfinished packet. A behavioural model checks every output byte on every clock. Each completed packet is also judged on its own: the bench compares its field bytes with the descriptor values given at its start and checks the CRC residue over all of its bytes.

// File: rtl/aal5_tail_pkg.sv
package aal5_tail_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam int FLD_W  = 16;

  // What the datapath places on the output for the current byte.
  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_FIELD = 2'd1,
    SEL_CRC   = 2'd2
  } byteSel_e;

  // Strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic     accept;     // a byte is taken this cycle
    logic     restart;    // packet start: preset CRC, latch fields
    logic     accumulate; // fold the emitted byte into the CRC
    byteSel_e sel;        // output byte source
    logic [1:0] lane;     // byte lane within the 32-bit tail word
    logic     cellEnd;    // byte is the last of its cell
  } dpStrobe_t;

endpackage

// File: rtl/aal5_tail_ctrl.sv
module aal5_tail_ctrl
  import aal5_tail_pkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSop,
  input  logic      inLast,
  output dpStrobe_t strobe
);

  localparam int POS_W       = $clog2(CELL_BYTES);
  localparam int FIELD_START = CELL_BYTES - 8;
  localparam int CRC_START   = CELL_BYTES - 4;

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] curPos;
  logic             inTail;
  logic             inCrc;
  logic             atEnd;

  // A start marker forces position 0 in the same cycle.
  always_comb begin
    curPos = inSop ? '0 : posQ;
    inTail = inLast && (curPos >= POS_W'(FIELD_START));
    inCrc  = inLast && (curPos >= POS_W'(CRC_START));
    atEnd  = (curPos == POS_W'(CELL_BYTES - 1));
  end

  always_comb begin
    strobe.accept     = inValid;
    strobe.restart    = inValid && inSop;
    strobe.accumulate = inValid && !inCrc;
    strobe.lane       = curPos[1:0];
    strobe.cellEnd    = atEnd;
    if (inCrc)       strobe.sel = SEL_CRC;
    else if (inTail) strobe.sel = SEL_FIELD;
    else             strobe.sel = SEL_PASS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
    end else if (inValid) begin
      posQ <= atEnd ? '0 : curPos + POS_W'(1);
    end
  end

endmodule

// File: rtl/aal5_tail_dp.sv
module aal5_tail_dp
  import aal5_tail_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] PRESET = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inSop,
  input  logic              inLast,
  input  logic [FLD_W-1:0]  descCtrl,
  input  logic [FLD_W-1:0]  descLen,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outSop,
  output logic              outLast,
  output logic              outCellEnd
);

  logic [CRC_W-1:0]          crcQ;
  logic [CRC_W-1:0]          crcBase;
  logic [CRC_W-1:0]          crcSent;
  logic [FLD_W-1:0]          ctrlQ;
  logic [FLD_W-1:0]          lenQ;
  logic [2*FLD_W-1:0]        tailWord;
  logic [BYTE_W-1:0]         byteMux;
  logic [BYTE_W:0][CRC_W-1:0] chain;

  assign crcBase  = strobe.restart ? PRESET : crcQ;
  assign crcSent  = ~crcQ;
  assign tailWord = {ctrlQ, lenQ};

  // Lane 0 is the most significant byte of each 32-bit word.
  always_comb begin
    case (strobe.sel)
      SEL_FIELD: byteMux = tailWord[{~strobe.lane, 3'b000} +: BYTE_W];
      SEL_CRC:   byteMux = crcSent[{~strobe.lane, 3'b000} +: BYTE_W];
      default:   byteMux = inData;
    endcase
  end

  // One shift stage per data bit, most significant bit first.
  assign chain[0] = crcBase;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_crcBit
    logic fb;
    assign fb         = chain[i][CRC_W-1] ^ byteMux[BYTE_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ  <= PRESET;
      ctrlQ <= '0;
      lenQ  <= '0;
    end else begin
      if (strobe.accumulate) crcQ <= chain[BYTE_W];
      if (strobe.restart) begin
        ctrlQ <= descCtrl;
        lenQ  <= descLen;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outSop     <= 1'b0;
      outLast    <= 1'b0;
      outCellEnd <= 1'b0;
    end else begin
      outValid <= strobe.accept;
      if (strobe.accept) begin
        outData    <= byteMux;
        outSop     <= inSop;
        outLast    <= inLast;
        outCellEnd <= strobe.cellEnd;
      end else begin
        outSop     <= 1'b0;
        outLast    <= 1'b0;
        outCellEnd <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aal5_tail_gen.sv
module aal5_tail_gen
  import aal5_tail_pkg::*;
#(
  parameter int          CELL_BYTES = 48,
  parameter logic [31:0] POLY       = 32'h04C11DB7,
  parameter logic [31:0] PRESET     = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inSop,
  input  logic        inLast,
  input  logic [15:0] descCtrl,
  input  logic [15:0] descLen,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outSop,
  output logic        outLast,
  output logic        outCellEnd
);

  dpStrobe_t strobe;

  aal5_tail_ctrl #(
    .CELL_BYTES(CELL_BYTES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inSop  (inSop),
    .inLast (inLast),
    .strobe (strobe)
  );

  aal5_tail_dp #(
    .POLY  (POLY),
    .PRESET(PRESET)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .inSop     (inSop),
    .inLast    (inLast),
    .descCtrl  (descCtrl),
    .descLen   (descLen),
    .outValid  (outValid),
    .outData   (outData),
    .outSop    (outSop),
    .outLast   (outLast),
    .outCellEnd(outCellEnd)
  );

endmodule

// File: rtl/aal5_tail_chk.sv
module aal5_tail_chk #(
  parameter int CELL_BYTES = 48
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       inSop,
  input logic       inLast,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outSop,
  input logic       outLast,
  input logic       outCellEnd
);

  localparam int CNT_W = $clog2(CELL_BYTES);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] curCnt;

  // Output bytes counted from the last emitted packet start.
  assign curCnt = outSop ? '0 : cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (outValid)
      cntQ <= (curCnt == CNT_W'(CELL_BYTES - 1)) ? '0 : curCnt + CNT_W'(1);
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rstN) |-> !outValid);

  assert_markers_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outValid && outSop == $past(inSop) && outLast == $past(inLast)));

  assert_payload_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inLast) |=> (outData == $past(inData)));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_cell_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCellEnd == (curCnt == CNT_W'(CELL_BYTES - 1))));

endmodule

bind aal5_tail_gen aal5_tail_chk #(
  .CELL_BYTES(CELL_BYTES)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inData    (inData),
  .inSop     (inSop),
  .inLast    (inLast),
  .outValid  (outValid),
  .outData   (outData),
  .outSop    (outSop),
  .outLast   (outLast),
  .outCellEnd(outCellEnd)
);

// File: tb/aal5_tail_gen_tb_top.sv
module aal5_tail_gen_tb_top;

  localparam int CELL = 48;
  localparam logic [31:0] POLY = 32'h04C11DB7;
  localparam logic [31:0] RESIDUE = 32'hC704DD7B;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic [15:0] descCtrl = '0, descLen = '0;
  logic outValid, outSop, outLast, outCellEnd;
  logic [7:0] outData;

  aal5_tail_gen dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inSop(inSop), .inLast(inLast), .descCtrl(descCtrl), .descLen(descLen),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outLast(outLast), .outCellEnd(outCellEnd)
  );

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;
  logic [31:0] lfsr = 32'h1D2C3B4A;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Software CRC: byte placed in the top of the register, then eight shifts.
  function automatic logic [31:0] swCrc(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {d, 24'h0};
    for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  int mPos = 0;
  logic [31:0] mCrc = 32'hFFFFFFFF;
  logic [31:0] mTail = '0;
  logic [31:0] mFin;
  logic [7:0] mByte;
  int mP;
  logic eValid = 1'b0, eSop = 1'b0, eLast = 1'b0, eEnd = 1'b0;
  logic [7:0] eData = '0;
  string eTag = "R2";

  always @(posedge clk) begin
    if (!rstN) begin
      eValid = 1'b0; mPos = 0; mCrc = 32'hFFFFFFFF;
    end else begin
      eValid = inValid;
      if (inValid) begin
        mP = inSop ? 0 : mPos;
        if (inSop) begin
          mCrc = 32'hFFFFFFFF;           // R7 preset on every start
          mTail = {descCtrl, descLen};   // R6 sampled only here
        end
        mByte = inData;
        eTag = "R2";
        if (inLast && mP >= CELL - 4) begin
          mFin = ~mCrc;
          mByte = mFin[8*(CELL-1-mP) +: 8];
          eTag = "R5";
        end else begin
          if (inLast && mP >= CELL - 8) begin
            mByte = mTail[8*(CELL-5-mP) +: 8];
            eTag = "R4";
          end
          mCrc = swCrc(mCrc, mByte);
        end
        eData = mByte; eSop = inSop; eLast = inLast;
        eEnd = (mP == CELL - 1);
        mPos = (mP == CELL - 1) ? 0 : mP + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      if (outValid !== eValid)
        check(1'b0, "R9 valid", {31'b0, outValid}, {31'b0, eValid});
      else if (eValid) begin
        if (outData !== eData) check(1'b0, eTag, {24'b0, outData}, {24'b0, eData});
        else if (outCellEnd !== eEnd) check(1'b0, "R8 cellEnd", {31'b0, outCellEnd}, {31'b0, eEnd});
        else check(outSop === eSop && outLast === eLast, "R2 markers",
                   {30'b0, outSop, outLast}, {30'b0, eSop, eLast});
      end else check(1'b1, "R9", 0, 0);
    end
  end

  // ---------------- per-packet judge ----------------
  logic [7:0] pkt[$];
  logic [31:0] qTail[$];
  int qCells[$];
  string qTag[$];

  task automatic judgePacket();
    logic [31:0] tw, c, fw;
    int cells, b;
    string tag;
    if (qCells.size() == 0) begin
      check(1'b0, "R2 unexpected packet end", 1, 0);
      return;
    end
    tw = qTail.pop_front(); cells = qCells.pop_front(); tag = qTag.pop_front();
    check(pkt.size() == cells * CELL, "R8 packet byte count", pkt.size(), cells * CELL);
    if (pkt.size() != cells * CELL) return;
    b = (cells - 1) * CELL + CELL - 8;
    fw = {pkt[b], pkt[b+1], pkt[b+2], pkt[b+3]};
    check(fw == tw, "R4/R6 tail fields", fw, tw);
    c = 32'hFFFFFFFF;
    foreach (pkt[i]) c = swCrc(c, pkt[i]);
    check(c == RESIDUE, {tag, " CRC residue (R5)"}, c, RESIDUE);
  endtask

  always @(negedge clk) begin
    if (cmpOn && outValid) begin
      if (outSop) pkt.delete();
      pkt.push_back(outData);
      if (outLast && outCellEnd) judgePacket();
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(logic [7:0] d, logic s, logic l, logic [15:0] c, logic [15:0] n);
    @(negedge clk);
    inValid = 1'b1; inData = d; inSop = s; inLast = l; descCtrl = c; descLen = n;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inLast = 1'b0; inData = 8'hA5;
  endtask

  // stopAt >= 0 cuts the packet short after that many bytes (R7 stimulus)
  task automatic sendPacket(int cells, logic [15:0] c, logic [15:0] n, int gap,
                            bit scramble, string tag, int stopAt);
    if (stopAt < 0) begin
      qTail.push_back({c, n}); qCells.push_back(cells); qTag.push_back(tag);
    end
    for (int k = 0; k < cells * CELL; k++) begin
      if (stopAt >= 0 && k == stopAt) return;
      if (gap > 0 && (k % gap) == gap - 1) idle();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k == 0 || !scramble) drive(lfsr[7:0], k == 0, (k / CELL) == cells - 1, c, n);
      else drive(lfsr[7:0], 1'b0, (k / CELL) == cells - 1, ~c ^ 16'(k), n + 16'(k)); // R6
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1 during reset", {31'b0, outValid}, 0);
    rstN = 1'b1;
    @(posedge clk);
    cmpOn = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 after release", {31'b0, outValid}, 0);

    // R3 R4 R5: single-cell packet
    sendPacket(1, 16'h1234, 16'h0028, 0, 1'b0, "R3", -1);
    idle();
    // R3: two cells with idle gaps (R9)
    sendPacket(2, 16'hBEEF, 16'h0050, 7, 1'b0, "R3", -1);
    idle(); idle();
    // R6 R8: many cells, descriptor changes mid-packet, odd length value
    sendPacket(5, 16'h00C3, 16'hFFFF, 0, 1'b1, "R3", -1);
    // R7: abort in mid cell, then restart with no gap
    sendPacket(3, 16'h7777, 16'h0001, 0, 1'b0, "R7", 20);
    sendPacket(2, 16'hA0A0, 16'h0060, 0, 1'b0, "R7", -1);
    // R7: restart inside a trailer (last cell, byte 45)
    sendPacket(1, 16'h5555, 16'h0002, 0, 1'b0, "R7", 45);
    sendPacket(1, 16'h0F0F, 16'h0003, 5, 1'b0, "R7", -1);
    // back-to-back single-cell packets
    for (int p = 0; p < 3; p++)
      sendPacket(1, 16'(p * 16'h1111), 16'(p + 9), 0, 1'b0, "R3", -1);
    sendPacket(4, 16'hFFFF, 16'h0000, 11, 1'b1, "R3", -1);
    idle(); idle(); idle();
    check(qCells.size() == 0, "R2 all packets emitted", qCells.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int wdCycles = 0;
  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d expected=done", wdCycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule